// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synchronous static memory that lets reads and writes follow each other on every clock with no idle cycle between them. Address, chip enables, read/write control and byte enables are taken on the rising clock edge. Write data trails its address, so a write issued directly after a read finds the data bus free while the read result is still on its way out. A static mode pin picks one of two timings. Pipelined timing registers the read result, and write data arrives two edges after the address. Flow-through timing drives the read result straight from the array, and write data arrives one edge after the address.

The array holds words of several 9-bit bytes, and each byte has its own write enable. Three chip enables of mixed polarity allow several devices to share one bus for depth expansion. An advance input steps through a four-beat burst in place of a new address, using either a linear or an interleaved order. Output enable and sleep act without waiting for a clock edge. While sleep is high the block ignores new commands and holds its contents.

Top module: `noturn_sram`

## Requirements
- R1: A new command is taken only when sel_a_n=0, sel_b=1 and sel_c_n=0 at the edge and step=0. In any other case without step the edge is a no-op: a write changes no memory and a read drives no data.
- R2: In pipelined mode (pipe_mode=1), read data for an address taken at edge t is driven between edges t+1 and t+2.
- R3: In flow-through mode (pipe_mode=0), read data for an address taken at edge t is driven between edges t and t+1.
- R4: In pipelined mode, write data for an address taken at edge t is sampled from wdata at edge t+2.
- R5: In flow-through mode, write data for an address taken at edge t is sampled from wdata at edge t+1.
- R6: Byte enables byte_we_n are sampled with the address. Bit i low writes bits 9i+8..9i of the word, and the other bytes keep their contents.
- R7: Any mix of reads and writes runs on consecutive edges. A read always returns the data of every write taken before it, including writes whose data has not yet reached the array, merged byte by byte with the stored word.
- R8: With burst_ilv=0, each edge with step=1 after a taken command repeats that command's operation at an address whose upper bits equal the base address. Its low two bits are (base + n) mod 4, where n counts the steps from 1 to 3 and wraps to 0.
- R9: With burst_ilv=1 the low two bits of a burst step are base XOR n.
- R10: out_en_n=1 forces rdata_oe low at once, without waiting for a clock edge.
- R11: While sleep=1, rdata_oe is low at once, commands and steps sampled at an edge are ignored, the burst position is held, and memory keeps its contents.
- R12: After reset rdata_oe is low, and no write or burst is pending.
- R13: step=1 after a no-op edge, or after reset, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static: 1 interleaved burst, 0 linear burst |
| sleep | input | 1 | Asynchronous sleep |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| step | input | 1 | Advance the burst in place of a new address |
| wr_n | input | 1 | 0 write, 1 read |
| byte_we_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address |
| wdata | input | 9*NB | Late write data |
| rdata | output | 9*NB | Read data, zero when not driven |
| rdata_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The bench builds the block with AW=4 and NB=4, so there are 16 words of four bytes. It first writes every word in full, which makes every later read predictable. With so few words, random traffic keeps hitting addresses whose writes are still in flight, which exercises the forwarding path. Bursts wrap inside the short address range and meet their own earlier writes. Both timing modes and both burst orders run in one pass, with a reset before each mode change.

// File: rtl/noturn_sram.sv
module noturn_sram #(
  parameter int AW = 8,
  parameter int NB = 4,
  localparam int W = 9 * NB,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          burst_ilv,
  input  logic          sleep,
  input  logic          out_en_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          step,
  input  logic          wr_n,
  input  logic [NB-1:0] byte_we_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          rdata_oe
);
  typedef enum logic [1:0] {OP_NOP, OP_RD, OP_WR} op_t;

  logic [W-1:0] mem [DEPTH];

  op_t           s1_op, s2_op, b_op, new_op;
  logic [AW-1:0] s1_a, s2_a, b_base, new_a;
  logic [NB-1:0] s1_be, s2_be;
  logic [1:0]    b_cnt, cnt_nx, lo_nx;
  logic          b_live, sel, cont;
  logic [W-1:0]  rd_raw, rd_fwd, q_pipe;

  assign sel    = !sel_a_n && sel_b && !sel_c_n;
  assign cont   = step && b_live;
  assign cnt_nx = b_cnt + 2'd1;
  assign lo_nx  = burst_ilv ? (b_base[1:0] ^ cnt_nx) : (b_base[1:0] + cnt_nx);
  assign new_a  = cont ? {b_base[AW-1:2], lo_nx} : addr;

  always_comb begin
    if (sleep)            new_op = OP_NOP;
    else if (cont)        new_op = b_op;
    else if (!step && sel) new_op = wr_n ? OP_RD : OP_WR;
    else                  new_op = OP_NOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op  <= OP_NOP;
      s2_op  <= OP_NOP;
      s1_a   <= '0;
      s2_a   <= '0;
      s1_be  <= '0;
      s2_be  <= '0;
      b_op   <= OP_NOP;
      b_base <= '0;
      b_cnt  <= '0;
      b_live <= 1'b0;
      q_pipe <= '0;
    end else begin
      s1_op  <= new_op;
      s1_a   <= new_a;
      s1_be  <= ~byte_we_n;
      s2_op  <= s1_op;
      s2_a   <= s1_a;
      s2_be  <= s1_be;
      q_pipe <= rd_fwd;
      if (!sleep) begin
        if (cont) begin
          b_cnt <= cnt_nx;
        end else if (!step) begin
          b_live <= sel;
          b_base <= addr;
          b_cnt  <= '0;
          b_op   <= wr_n ? OP_RD : OP_WR;
        end
      end
    end
  end

  // late write: two edges behind the address when pipelined, one otherwise
  logic          wr_go;
  logic [AW-1:0] wr_a;
  logic [NB-1:0] wr_be;
  assign wr_go = pipe_mode ? (s2_op == OP_WR) : (s1_op == OP_WR);
  assign wr_a  = pipe_mode ? s2_a : s1_a;
  assign wr_be = pipe_mode ? s2_be : s1_be;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (wr_go && wr_be[i]) mem[wr_a][9*i +: 9] <= wdata[9*i +: 9];
  end

  // a pipelined read may meet the write whose data lands on this same edge
  assign rd_raw = mem[s1_a];
  for (genvar g = 0; g < NB; g++) begin : g_fwd
    assign rd_fwd[9*g +: 9] = (pipe_mode && s2_op == OP_WR && s2_a == s1_a && s2_be[g])
                              ? wdata[9*g +: 9] : rd_raw[9*g +: 9];
  end

  assign rdata_oe = (pipe_mode ? (s2_op == OP_RD) : (s1_op == OP_RD)) && !out_en_n && !sleep;
  assign rdata    = rdata_oe ? (pipe_mode ? q_pipe : rd_raw) : '0;

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && !step && !sel) |=> !rdata_oe);

  assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !sleep && !step && sel && wr_n) |-> ##2 (rdata_oe || out_en_n || sleep));

  assert_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sleep && !step && sel && wr_n) |=> (rdata_oe || out_en_n || sleep));

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && b_live && !sleep) |=> (b_cnt == $past(b_cnt) + 2'd1));

  assert_sleep_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_op == OP_NOP && $stable(b_cnt)));

  assert_step_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !b_live) |=> (s1_op == OP_NOP));
endmodule

// File: tb/sim_noturn_sram.sv
`timescale 1ns/1ps
module sim_noturn_sram;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int W  = 9 * NB;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0, pipe_mode = 0, burst_ilv = 0, sleep = 0, out_en_n = 0;
  logic sel_a_n = 1, sel_b = 1, sel_c_n = 0, step = 0, wr_n = 1;
  logic [NB-1:0] byte_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0, rdata;
  logic          rdata_oe;

  always #4 clk = ~clk;

  noturn_sram #(.AW(AW), .NB(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .sleep(sleep), .out_en_n(out_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .step(step), .wr_n(wr_n), .byte_we_n(byte_we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  typedef struct {int a; logic [NB-1:0] be; int due;} pend_t;
  pend_t pq[$];
  pend_t rq[$];
  logic [W-1:0] mm [NW];
  int edge_n = 0, bbase = 0, bcnt = 0, bop = 0;
  bit blive = 0, exp_v = 0;
  logic [W-1:0] exp_q = '0;
  int total = 0, bad = 0;
  string tag = "R12";

  task automatic chk(bit ok, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at edge %0d actual=%h expected=%h", tag, what, edge_n, act, exp);
    end
  endtask

  task automatic model_edge();
    int a, op;
    bit sel;
    a = 0;
    op = 0;
    edge_n++;
    while (pq.size() > 0 && pq[0].due == edge_n) begin
      for (int i = 0; i < NB; i++)
        if (pq[0].be[i]) mm[pq[0].a][9*i +: 9] = wdata[9*i +: 9];
      void'(pq.pop_front());
    end
    sel = !sel_a_n && sel_b && !sel_c_n;
    if (!sleep) begin
      if (step) begin
        if (blive) begin
          bcnt = (bcnt + 1) % 4;
          a = (bbase & ~3) | (burst_ilv ? ((bbase & 3) ^ bcnt) : (((bbase & 3) + bcnt) % 4));
          op = bop;
        end
      end else if (sel) begin
        blive = 1; bbase = int'(addr); bcnt = 0; bop = wr_n ? 1 : 2;
        a = bbase; op = bop;
      end else begin
        blive = 0;
      end
    end
    if (op == 2) pq.push_back('{a, ~byte_we_n, edge_n + (pipe_mode ? 2 : 1)});
    if (op == 1) rq.push_back('{a, '0, edge_n + (pipe_mode ? 1 : 0)});
    exp_v = 0;
    if (rq.size() > 0 && rq[0].due == edge_n) begin
      exp_v = 1;
      exp_q = mm[rq[0].a];
      void'(rq.pop_front());
    end
  endtask

  task automatic tick();
    bit eo;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    eo = exp_v && !out_en_n && !sleep;
    chk(rdata_oe == eo, "oe", W'(rdata_oe), W'(eo));
    if (eo) chk(rdata == exp_q, "data", rdata, exp_q);
  endtask

  task automatic drive(bit s, bit c1n, bit c2, bit c3n, bit adv, bit w_n, logic [NB-1:0] bw, int ad);
    sleep = s; sel_a_n = c1n; sel_b = c2; sel_c_n = c3n; step = adv; wr_n = w_n;
    byte_we_n = bw; addr = AW'(ad); wdata = {$urandom, $urandom};
    tick();
  endtask

  task automatic wr(int ad, logic [NB-1:0] bw); drive(0, 0, 1, 0, 0, 0, bw, ad); endtask
  task automatic rd(int ad); drive(0, 0, 1, 0, 0, 1, '1, ad); endtask
  task automatic nop(); drive(0, 1, 1, 0, 0, 1, '1, 0); endtask
  task automatic adv(); drive(0, 1, 1, 0, 1, 1, '1, 0); endtask
  task automatic advw(logic [NB-1:0] bw); drive(0, 1, 1, 0, 1, 0, bw, 0); endtask

  task automatic oe_probe();
    if (exp_v) begin
      out_en_n = 1; #1;
      chk(rdata_oe == 0, "async oe off", W'(rdata_oe), '0);
      out_en_n = 0; #1;
      chk(rdata_oe == 1, "async oe on", W'(rdata_oe), W'(1));
    end
  endtask

  task automatic sleep_probe();
    if (exp_v) begin
      sleep = 1; #1;
      chk(rdata_oe == 0, "async sleep", W'(rdata_oe), '0);
      sleep = 0; #1;
    end
  endtask

  task automatic do_reset(bit pm);
    @(negedge clk);
    rst_n = 0; step = 0; sleep = 0; sel_a_n = 1;
    pipe_mode = pm;
    repeat (3) @(negedge clk);
    pq.delete(); rq.delete(); blive = 0; bcnt = 0; exp_v = 0;
    rst_n = 1;
    tag = "R12";
    chk(rdata_oe == 0, "reset oe", W'(rdata_oe), '0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_200_000;
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      burst_ilv = 0;
      nop(); nop();
      tag = m ? "R4" : "R5";
      for (int a = 0; a < NW; a++) wr(a, '0);
      nop(); nop(); nop();
      tag = m ? "R2" : "R3";
      for (int a = 0; a < NW; a++) rd(a);
      nop(); nop();
      tag = "R6";
      wr(2, 4'b1010); wr(3, 4'b0110); nop(); nop();
      rd(2); rd(3); nop(); nop();
      tag = "R7";
      for (int i = 0; i < 40; i++) begin
        int a;
        a = $urandom_range(0, 3);
        if (i % 2 == 0) wr(a, 4'($urandom)); else rd(a);
      end
      wr(7, '0); rd(7); wr(7, 4'b1100); rd(7); rd(7); nop(); nop();
      tag = "R8";
      rd(5); adv(); adv(); adv(); adv(); nop();
      wr(9, '0); advw('0); advw(4'b0101); advw('0); nop(); nop();
      rd(9); adv(); adv(); adv(); nop(); nop();
      tag = "R9";
      burst_ilv = 1;
      rd(6); adv(); adv(); adv(); nop();
      wr(13, '0); advw('0); advw(4'b0011); advw('0); nop(); nop();
      rd(12); adv(); adv(); adv(); nop(); nop();
      burst_ilv = 0;
      tag = "R1";
      drive(0, 1, 1, 0, 0, 0, '0, 4); drive(0, 0, 0, 0, 0, 0, '0, 4);
      drive(0, 0, 1, 1, 0, 0, '0, 4); drive(0, 1, 1, 0, 0, 1, '1, 4);
      drive(0, 0, 0, 0, 0, 1, '1, 4); nop(); nop();
      rd(4); nop(); nop();
      tag = "R13";
      nop(); adv(); advw('0); adv(); nop(); nop(); rd(0); nop(); nop();
      tag = "R10";
      rd(3); oe_probe(); nop(); oe_probe(); nop();
      out_en_n = 1; rd(8); nop(); out_en_n = 0; nop();
      tag = "R11";
      rd(1); sleep_probe(); nop(); sleep_probe(); nop();
      rd(10); drive(1, 0, 1, 0, 0, 0, '0, 10); drive(1, 1, 1, 0, 1, 1, '1, 0);
      adv(); nop(); nop(); rd(10); rd(11); nop(); nop();
      tag = "R7";
      for (int i = 0; i < 300; i++) begin
        int r;
        r = $urandom_range(0, 99);
        out_en_n = ($urandom_range(0, 9) == 0);
        if (r < 8) drive(1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                         $urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom), $urandom_range(0, NW - 1));
        else if (r < 25) drive(0, 1, 1, 0, 1, 1, 4'($urandom), 0);
        else if (r < 33) drive(0, $urandom_range(0, 1), $urandom_range(0, 1), 1, 0,
                               $urandom_range(0, 1), 4'($urandom), $urandom_range(0, NW - 1));
        else if (r < 66) wr($urandom_range(0, NW - 1), 4'($urandom));
        else rd($urandom_range(0, NW - 1));
      end
      out_en_n = 0;
      nop(); nop(); nop();
    end
    summary();
    $finish;
  end
endmodule